// File: doc/BRIEF.md
# Open-Row DRAM Controller with Interleaved Refresh

This block is a memory controller for a small behavioural DRAM of sixteen 8-bit supercells arranged as a 4 by 4 grid. A requester presents single-byte reads and writes on a valid/ready port. The controller splits each 4-bit supercell address into a row and a column and sends them one after the other over a shared 2-bit address bus. A row strobe moves the addressed row into the array's row buffer, a column strobe selects one byte of that buffer, and a close (precharge) command writes the buffer back into the cell array.

The controller leaves the last row open after each access. A following access to the same row therefore needs only a column strobe, and an access to a different row first closes the open row. A free-running counter with a programmable period raises a refresh request. Once the current access has finished, the refresh takes priority over new requests: it closes any open row and then opens and closes each of the four rows in ascending order.

The command bus is brought out as ports so that the commands can be observed and counted.

Top module: `dram_rowbuf_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and all three command strobes are 0, and every supercell reads back as 0.
- R2: The supercell address splits as row = req_addr[3:2] and column = req_addr[1:0]. A row strobe carries the row on mem_addr, and a column strobe carries the column on mem_addr, with mem_we = 1 for a write.
- R3: A read returns the stored byte on rsp_rdata with rsp_valid high for exactly one cycle. Counting from the accepting clock edge, rsp_valid appears after 2 edges when the row is already open and after 3 edges when no row is open.
- R4: A write changes the addressed byte in the row buffer. The byte reaches the cell array when that row is closed, so a later read returns it even after other rows have been used in between.
- R5: Consecutive accesses to the row that is already open issue no row strobe. Over any sequence with no refresh, the number of row strobes equals the number of accesses whose row differs from the row left open.
- R6: An access to a row other than the open one issues one precharge and then one row strobe before its column strobe. A read of this kind has a latency of 4 edges.
- R7: With no traffic, refresh bursts recur exactly every refresh_period cycles. refresh_period must be at least 16.
- R8: A refresh burst issues row strobes for rows 0, 1, 2 and 3 in that order, two cycles apart, each followed by a precharge. No row is open after the burst.
- R9: A pending refresh blocks new requests and begins within 4 cycles. Stored data survive refresh under continuous traffic, and bursts keep their rate.
- R10: At most one of mem_ras, mem_cas and mem_pre is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_period | input | 16 | Refresh interval in cycles (at least 16) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Supercell address, row in the upper 2 bits |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_ras | output | 1 | Row strobe |
| mem_cas | output | 1 | Column strobe |
| mem_pre | output | 1 | Row close / write-back |
| mem_we | output | 1 | Column strobe is a write |
| mem_addr | output | 2 | Shared row/column address bus |

## Verification
The assertions assume that refresh_period is at least the length of a burst and stays constant while a burst is running. Under that assumption the 4-cycle bound on refresh waiting and the strobe ordering inside the array hold. The stimulus uses only two period values, 60000 and 20, and changes the period only while the controller is idle. It issues one request at a time and waits for each one to complete before the next. Latency and row-strobe counts are predicted only in the phases where the long period rules out refresh. With the short period, the bench checks data integrity and measures the burst rate instead.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  localparam int SIDE_BITS_DEF = 2;
  localparam int DATA_W_DEF    = 8;
  localparam int PERIOD_W_DEF  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_CAS, ST_RPRE, ST_RACT, ST_RCLOSE
  } ctl_state_e;
endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int SIDE_BITS = dramc_pkg::SIDE_BITS_DEF,
  parameter int DATA_W    = dramc_pkg::DATA_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras,
  input  logic                 cas,
  input  logic                 pre,
  input  logic                 we,
  input  logic [SIDE_BITS-1:0] addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata
);
  localparam int SIDE = 1 << SIDE_BITS;

  logic [DATA_W-1:0]    cells  [SIDE][SIDE];
  logic [DATA_W-1:0]    rowbuf [SIDE];
  logic [SIDE_BITS-1:0] held_row;
  logic                 bank_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < SIDE; r++)
        for (int c = 0; c < SIDE; c++) cells[r][c] <= '0;
      for (int c = 0; c < SIDE; c++) rowbuf[c] <= '0;
      held_row  <= '0;
      bank_open <= 1'b0;
    end else begin
      if (ras) begin
        for (int c = 0; c < SIDE; c++) rowbuf[c] <= cells[addr][c];
        held_row  <= addr;
        bank_open <= 1'b1;
      end
      if (cas && we) rowbuf[addr] <= wdata;
      if (pre) begin
        for (int c = 0; c < SIDE; c++) cells[held_row][c] <= rowbuf[c];
        bank_open <= 1'b0;
      end
    end
  end

  assign rdata = rowbuf[addr];

  // R6: a row can only be opened into a closed bank
  a_r6_ras_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ras |-> !bank_open);
  // R8: column access requires an open row, including right after refresh
  a_r8_cas_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    cas |-> bank_open);
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD_W = dramc_pkg::PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic                take,
  output logic                pending
);
  logic [PERIOD_W-1:0] cnt;
  logic                wrap;

  function automatic logic period_done(input logic [PERIOD_W-1:0] c,
                                       input logic [PERIOD_W-1:0] p);
    return ({1'b0, c} + 1'b1) >= {1'b0, p};
  endfunction

  assign wrap = period_done(cnt, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)      pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dramc_pkg::*;
#(
  parameter int SIDE_BITS = dramc_pkg::SIDE_BITS_DEF,
  parameter int DATA_W    = dramc_pkg::DATA_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [2*SIDE_BITS-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_pending,
  output logic                   ref_take,
  output logic                   cmd_ras,
  output logic                   cmd_cas,
  output logic                   cmd_pre,
  output logic                   cmd_we,
  output logic [SIDE_BITS-1:0]   cmd_addr,
  output logic [DATA_W-1:0]      cmd_wdata,
  input  logic [DATA_W-1:0]      cell_rdata
);
  localparam int ADDR_W = 2 * SIDE_BITS;
  localparam logic [SIDE_BITS-1:0] LAST_ROW = SIDE_BITS'((1 << SIDE_BITS) - 1);

  function automatic logic [SIDE_BITS-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SIDE_BITS];
  endfunction
  function automatic logic [SIDE_BITS-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[SIDE_BITS-1:0];
  endfunction

  ctl_state_e           state;
  logic                 row_open;
  logic [SIDE_BITS-1:0] open_row, cur_row, cur_col, ref_row;
  logic                 cur_write;
  logic [DATA_W-1:0]    cur_wdata;
  logic                 accept, row_hit;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_take  = (state == ST_IDLE) && ref_pending;
  assign accept    = req_valid && req_ready;
  assign row_hit   = row_open && (open_row == row_of(req_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      row_open  <= 1'b0;
      open_row  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_write <= 1'b0;
      cur_wdata <= '0;
      ref_row   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (state == ST_CAS) && !cur_write;
      if (state == ST_CAS && !cur_write) rsp_rdata <= cell_rdata;
      case (state)
        ST_IDLE: begin
          if (ref_take) begin
            ref_row <= '0;
            state   <= row_open ? ST_RPRE : ST_RACT;
          end else if (accept) begin
            cur_row   <= row_of(req_addr);
            cur_col   <= col_of(req_addr);
            cur_write <= req_write;
            cur_wdata <= req_wdata;
            state     <= row_hit ? ST_CAS : (row_open ? ST_PRE : ST_ACT);
          end
        end
        ST_PRE: begin
          row_open <= 1'b0;
          state    <= ST_ACT;
        end
        ST_ACT: begin
          row_open <= 1'b1;
          open_row <= cur_row;
          state    <= ST_CAS;
        end
        ST_CAS:  state <= ST_IDLE;
        ST_RPRE: begin
          row_open <= 1'b0;
          state    <= ST_RACT;
        end
        ST_RACT: state <= ST_RCLOSE;
        ST_RCLOSE: begin
          if (ref_row == LAST_ROW) state <= ST_IDLE;
          else begin
            ref_row <= ref_row + 1'b1;
            state   <= ST_RACT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ras   = 1'b0;
    cmd_cas   = 1'b0;
    cmd_pre   = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = '0;
    cmd_wdata = cur_wdata;
    case (state)
      ST_PRE, ST_RPRE, ST_RCLOSE: cmd_pre = 1'b1;
      ST_ACT:  begin cmd_ras = 1'b1; cmd_addr = cur_row; end
      ST_RACT: begin cmd_ras = 1'b1; cmd_addr = ref_row; end
      ST_CAS:  begin cmd_cas = 1'b1; cmd_we = cur_write; cmd_addr = cur_col; end
      default: ;
    endcase
  end

  // refresh wait tracker for the bounded-delay check
  logic [3:0] ref_wait;
  always_ff @(posedge clk) begin
    if (!rst_n) ref_wait <= '0;
    else if (ref_pending && !ref_take) ref_wait <= (ref_wait == 4'hF) ? ref_wait : ref_wait + 1'b1;
    else ref_wait <= '0;
  end

  // R9: a pending refresh starts within 4 cycles
  a_r9_refresh_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wait <= 4'd4);
  // R3: read data pulse lasts exactly one cycle
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl #(
  parameter int SIDE_BITS = dramc_pkg::SIDE_BITS_DEF,
  parameter int DATA_W    = dramc_pkg::DATA_W_DEF,
  parameter int PERIOD_W  = dramc_pkg::PERIOD_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PERIOD_W-1:0]    refresh_period,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [2*SIDE_BITS-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   mem_ras,
  output logic                   mem_cas,
  output logic                   mem_pre,
  output logic                   mem_we,
  output logic [SIDE_BITS-1:0]   mem_addr
);
  logic              ref_pending, ref_take;
  logic [DATA_W-1:0] bus_wdata, cell_rdata;

  dram_refresh_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(refresh_period),
    .take(ref_take), .pending(ref_pending)
  );

  dram_seq_fsm #(.SIDE_BITS(SIDE_BITS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_pending(ref_pending), .ref_take(ref_take),
    .cmd_ras(mem_ras), .cmd_cas(mem_cas), .cmd_pre(mem_pre), .cmd_we(mem_we),
    .cmd_addr(mem_addr), .cmd_wdata(bus_wdata), .cell_rdata(cell_rdata)
  );

  dram_cell_array #(.SIDE_BITS(SIDE_BITS), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .ras(mem_ras), .cas(mem_cas), .pre(mem_pre), .we(mem_we),
    .addr(mem_addr), .wdata(bus_wdata), .rdata(cell_rdata)
  );

  // R10: one command per cycle on the shared bus
  a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_ras, mem_cas, mem_pre}));
  // R3: a response only follows a read column strobe
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_cas && !mem_we));
endmodule

// File: tb/tb_dram_rowbuf_ctrl.sv
module tb_dram_rowbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] refresh_period = 16'd60000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_ras, mem_cas, mem_pre, mem_we;
  logic [7:0]  rsp_rdata;
  logic [1:0]  mem_addr;

  always #10 clk = ~clk;

  dram_rowbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .refresh_period(refresh_period),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ras(mem_ras), .mem_cas(mem_cas), .mem_pre(mem_pre),
    .mem_we(mem_we), .mem_addr(mem_addr)
  );

  int tests = 0, fails = 0, cyc = 0;
  int ras_total = 0, pre_total = 0, last_ras_addr = -1, last_cas_addr = -1;
  bit last_cas_we = 1'b0;
  int chain = 0, prev_ras_cyc = -100, prev_ras_row = -1, bursts = 0;
  int burst_end_q[$];
  byte unsigned refmem[16];
  int model_open = -1;
  int unsigned seed = 32'h1234_5678;

  // bus monitor: counts commands and recognises refresh bursts (rows 0..3, 2 cycles apart)
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_ras) begin
        ras_total++;
        last_ras_addr = int'(mem_addr);
        if (mem_addr == 2'd0) chain = 1;
        else if (chain > 0 && cyc - prev_ras_cyc == 2 && int'(mem_addr) == prev_ras_row + 1) chain++;
        else chain = 0;
        if (chain == 4) begin bursts++; burst_end_q.push_back(cyc); chain = 0; end
        prev_ras_cyc = cyc;
        prev_ras_row = int'(mem_addr);
      end
      if (mem_pre) pre_total++;
      if (mem_cas) begin last_cas_addr = int'(mem_addr); last_cas_we = mem_we; end
    end
    cyc++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  task automatic access(input bit wr, input int a, input int d, input bit tracked, input string tag);
    int row, col, exp_lat, lat, ras0, pre0;
    bit miss, conflict;
    row = a >> 2; col = a & 3;
    miss = (model_open != row);
    conflict = miss && (model_open >= 0);
    exp_lat = 2 + (miss ? 1 : 0) + (conflict ? 1 : 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 4'(a); req_wdata = 8'(d);
    while (!req_ready) @(negedge clk);
    ras0 = ras_total; pre0 = pre_total;
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      if (lat == 0) req_valid = 1'b0;
      lat++;
    end while (!(wr ? req_ready : rsp_valid) && lat < 40);
    if (!wr) begin
      check(rsp_valid && rsp_rdata == refmem[a], tag, int'(rsp_rdata), int'(refmem[a]));
      @(negedge clk);
      check(!rsp_valid, "R3 rsp_valid single cycle", int'(rsp_valid), 0);
    end else refmem[a] = 8'(d);
    if (tracked) begin
      check(lat == exp_lat, conflict ? "R6 conflict latency" : "R3 access latency", lat, exp_lat);
      check(ras_total - ras0 == (miss ? 1 : 0), "R5 row strobe per access", ras_total - ras0, miss ? 1 : 0);
      check(pre_total - pre0 == (conflict ? 1 : 0), "R6 precharge before row change",
            pre_total - pre0, conflict ? 1 : 0);
      if (miss) check(last_ras_addr == row, "R2 row on bus", last_ras_addr, row);
      check(last_cas_addr == col, "R2 column on bus", last_cas_addr, col);
      check(last_cas_we == wr, "R2 write flag on column strobe", int'(last_cas_we), int'(wr));
    end
    model_open = row;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r0, n, b0, c0;
    for (int i = 0; i < 16; i++) refmem[i] = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check({mem_ras, mem_cas, mem_pre} == 3'b000, "R1 no strobes after reset",
          int'({mem_ras, mem_cas, mem_pre}), 0);
    for (int a = 0; a < 16; a++) access(1'b0, a, 0, 1'b1, "R1 reset contents");

    // fill all supercells row by row
    for (int a = 0; a < 16; a++) access(1'b1, a, a * 17 + 3, 1'b1, "R4 write");
    // row 2 was written back when row 3 opened; four same-row reads need one row strobe
    r0 = ras_total;
    for (int c = 0; c < 4; c++) access(1'b0, 8 + c, 0, 1'b1, "R4 write-back readback");
    check(ras_total - r0 == 1, "R5 same-row run uses one row strobe", ras_total - r0, 1);
    // alternating rows force precharge + activate each time
    access(1'b0, 1, 0, 1'b1, "R6 conflict read data");
    access(1'b0, 13, 0, 1'b1, "R6 conflict read data");
    access(1'b0, 2, 0, 1'b1, "R6 conflict read data");
    // mixed random traffic with tracked latency and strobe counts
    for (int k = 0; k < 150; k++) access(rnd(2) == 1, rnd(16), rnd(256), 1'b1, "R4 random data");

    // idle refresh: open row 1, then shorten the period and observe bursts
    access(1'b1, 5, 8'h5A, 1'b1, "R4 write");
    @(negedge clk);
    burst_end_q.delete();
    refresh_period = 16'd20;
    repeat (130) @(negedge clk);
    n = burst_end_q.size();
    check(n >= 5, "R8 ordered refresh bursts seen", n, 5);
    for (int k = 1; k + 1 < n; k++)
      check(burst_end_q[k + 1] - burst_end_q[k] == 20, "R7 refresh period",
            burst_end_q[k + 1] - burst_end_q[k], 20);
    model_open = -1;
    access(1'b0, 5, 0, 1'b1, "R8 data after refresh");

    // continuous traffic with frequent refresh
    b0 = bursts; c0 = cyc;
    for (int k = 0; k < 150; k++) access(rnd(2) == 1, rnd(16), rnd(256), 1'b0, "R9 data under refresh");
    check(bursts - b0 >= (cyc - c0) / 20 - 2, "R9 refresh rate under traffic",
          bursts - b0, (cyc - c0) / 20 - 2);
    for (int a = 0; a < 16; a++) access(1'b0, a, 0, 1'b0, "R9 final contents");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule